// File: doc/BRIEF.md
# Packet SPI Master with Preload Buffer

This block is a mode-0 SPI master that sends a short command packet to one of eight addressed slaves and, on a read, collects a byte or a 16-bit response. Software first pushes up to six command bytes into a small buffer through a dedicated register offset. Then a single write or read at one of eight slave offsets sends the whole packet under one chip-select frame. The low three bits of the slave offset appear on three slave-address lines for external decoders.

A write to a slave offset sends the buffered bytes in the order they were loaded, followed by the written byte. A read from a slave offset sends the buffered bytes and then clocks in one response byte, or two when word receive is enabled in the configuration register. The high byte of a word response is fetched afterwards by reading the buffer offset. The serial clock is the system clock divided by a parameter. With the default of 13 cycles per half period at 125 MHz, the bit rate is just under 5 Mbit/s. While a packet is in flight the block reports busy, and requests made then are not taken.

Top module: `spi_pkt_master`

## Requirements
- R1: The serial clock idles low. MOSI changes only while the clock is low, each byte goes out MSB first, and MISO is sampled on the rising clock edge. Whenever chip select is high, the serial clock and MOSI are both low.
- R2: An access to offset 0 to 7 drives the slave-address lines with the offset's low three bits, and they hold that value for the whole packet. Chip select falls when the access is taken, stays low across all bytes, and rises together with the last falling clock edge.
- R3: A write to offset 8 pushes its data byte into a six-entry buffer. Writes to offset 8 while six bytes are already held are dropped.
- R4: A write to a slave offset sends the buffered bytes in load order, then the written byte, for a packet of 1 to 7 bytes.
- R5: A read from a slave offset sends the buffered bytes, then 8 clocks with MOSI low. The read data returns the byte received in those 8 clocks, first bit as the MSB.
- R6: Every slave-offset access empties the buffer, so the next access sends only newly loaded bytes.
- R7: Bit 0 of a write to offset 9 enables word receive, and it resets to 0. With word receive enabled, a slave read clocks 16 response bits with MOSI low and returns the second received byte as read data.
- R8: A read of offset 8 after a word read returns the first received byte of that word.
- R9: Each half period of the serial clock lasts HALF_DIV system clocks. The first rising edge comes HALF_DIV clocks after chip select falls.
- R10: bus_busy is high from the clock after a slave access is taken until the packet ends, and requests made while it is high are ignored. bus_done pulses for one clock when each taken access completes.
- R11: After reset, chip select is high, the serial clock and MOSI are low, the address lines are 0, and busy, done and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request, taken when bus_busy is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Offset: 0-7 slave ports, 8 buffer port, 9 configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when bus_done pulses |
| bus_busy | output | 1 | Packet in flight |
| bus_done | output | 1 | One-cycle completion pulse |
| spi_clk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select framing the packet |
| spi_sa | output | 3 | Slave-address lines |

## Verification
Assertions check the line-level rules on every cycle: the clock and MOSI stay quiet outside the frame, MOSI holds while the clock is high, the address lines hold inside a frame, chip select rises only off a high clock, and the buffer count never passes six. Only the bench's scenarios can show the packet contents. These cover load order, the written byte at the tail, zero bytes in the read phase, dropped overflow and busy-time loads, the buffer emptying between accesses, byte and word responses with the high byte fetched afterwards, and the clock edge spacing measured against chip select.

// File: rtl/spi_pkt_master.sv
module spi_pkt_master #(
  parameter int HALF_DIV = 13,
  parameter int DEPTH    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_busy,
  output logic       bus_done,
  output logic       spi_clk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic [2:0] spi_sa
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int IW = $clog2(DEPTH + 3);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    fifo [DEPTH];
  logic [IW-1:0] fcnt, ncnt, bidx, last_idx;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh, wbyte, rdata;
  logic [15:0]   rx;
  logic          run, word_en, is_wr, done, cs_n, mclk;
  logic [2:0]    sa;

  wire acc      = bus_req && !run;
  wire buf_push = acc && bus_we && bus_addr == 4'd8 && fcnt < IW'(DEPTH);

  function automatic logic [7:0] pick(input logic [IW-1:0] idx);
    if (idx < ncnt) return fifo[idx[AW-1:0]];
    else if (is_wr) return wbyte;
    else return 8'h00;
  endfunction

  always_ff @(posedge clk)
    if (buf_push) fifo[fcnt[AW-1:0]] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0; ncnt <= '0; bidx <= '0; last_idx <= '0; div <= '0;
      bitn <= '0; sh <= '0; wbyte <= '0; rdata <= '0; rx <= '0;
      run <= 1'b0; word_en <= 1'b0; is_wr <= 1'b0; done <= 1'b0;
      cs_n <= 1'b1; mclk <= 1'b0; sa <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (acc) begin
          if (!bus_addr[3]) begin
            run      <= 1'b1;
            cs_n     <= 1'b0;
            sa       <= bus_addr[2:0];
            is_wr    <= bus_we;
            wbyte    <= bus_wdata;
            ncnt     <= fcnt;
            last_idx <= fcnt + IW'(!bus_we && word_en);
            fcnt     <= '0;
            sh       <= (fcnt != '0) ? fifo[0] : (bus_we ? bus_wdata : 8'h00);
            bitn     <= '0;
            bidx     <= '0;
            div      <= '0;
          end else begin
            done <= 1'b1;
            if (bus_addr == 4'd8) begin
              if (!bus_we) rdata <= rx[15:8];
              else if (buf_push) fcnt <= fcnt + IW'(1);
            end else if (bus_addr == 4'd9 && bus_we) begin
              word_en <= bus_wdata[0];
            end
          end
        end
      end else if (div == DW'(HALF_DIV - 1)) begin
        div <= '0;
        if (!mclk) begin
          mclk <= 1'b1;
          rx   <= {rx[14:0], spi_miso};
        end else begin
          mclk <= 1'b0;
          if (bitn == 3'd7) begin
            if (bidx == last_idx) begin
              run  <= 1'b0;
              cs_n <= 1'b1;
              done <= 1'b1;
              sh   <= '0;
              if (!is_wr) rdata <= rx[7:0];
            end else begin
              bidx <= bidx + IW'(1);
              bitn <= '0;
              sh   <= pick(bidx + IW'(1));
            end
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

  assign bus_rdata = rdata;
  assign bus_busy  = run;
  assign bus_done  = done;
  assign spi_clk   = mclk;
  assign spi_mosi  = sh[7];
  assign spi_cs_n  = cs_n;
  assign spi_sa    = sa;

  // R1
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_clk && !spi_mosi));
  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_clk |=> (!spi_clk || $stable(spi_mosi)));
  // R2
  sa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |=> (spi_cs_n || $stable(spi_sa)));
  // R2
  cs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_clk));
  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= IW'(DEPTH));
endmodule

// File: tb/spi_pkt_master_test.sv
module spi_pkt_master_test;
  localparam int HALF = 13;
  localparam int TCK  = 8;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic bus_busy, bus_done, spi_clk, spi_mosi, spi_cs_n;
  logic spi_miso = 0;
  logic [2:0] spi_sa;

  always #4 clk = ~clk;

  spi_pkt_master #(.HALF_DIV(HALF), .DEPTH(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_busy(bus_busy), .bus_done(bus_done), .spi_clk(spi_clk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .spi_sa(spi_sa));

  int errors = 0, checks = 0;
  bit finished = 0;

  bit      mosi_q[$];
  time     rise_t[$];
  time     cs_fall_t;
  logic [2:0] sa_first;
  logic [63:0] pat = 64'hA5C3_3C96_0FF0_5AE1;
  int      sidx = 0;
  logic [2:0] exp_sa = 0;
  bit      sa_known = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  always @(negedge spi_cs_n) begin
    sidx = 0; spi_miso = pat[63];
    mosi_q.delete(); rise_t.delete(); cs_fall_t = $time;
  end
  always @(posedge spi_clk) begin
    if (mosi_q.size() == 0) sa_first = spi_sa;
    mosi_q.push_back(spi_mosi);
    rise_t.push_back($time);
  end
  always @(negedge spi_clk) begin
    if (sidx < 63) sidx++;
    spi_miso = pat[63 - sidx];
  end

  // per-clock comparison against expected line state
  always @(negedge clk) if (rst_n && !finished) begin
    if (spi_cs_n) chk("R1 idle lines", {spi_clk, spi_mosi}, 2'b00);
    else if (sa_known) chk("R2 address lines", spi_sa, exp_sa);
  end

  task automatic access(input logic we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    while (bus_busy) @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    if (!a[3]) begin exp_sa = a[2:0]; sa_known = 1; end
    @(negedge clk);
    bus_req = 0;
    while (!bus_done) @(negedge clk);
    sa_known = 0;
  endtask

  task automatic check_pkt(string req, logic [7:0] exp[$]);
    chk({req, " bit count"}, mosi_q.size(), 8 * exp.size());
    if (mosi_q.size() == 8 * exp.size())
      foreach (exp[i]) begin
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = mosi_q[8*i + k];
        chk({req, " byte"}, b, exp[i]);
      end
  endtask

  function automatic logic [7:0] rx_byte(int first_bit);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = pat[63 - (first_bit + k)];
    return b;
  endfunction

  initial begin
    #(TCK * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset lines", {spi_cs_n, spi_clk, spi_mosi, spi_sa}, 6'b100_000);
    chk("R11 reset bus", {bus_busy, bus_done, bus_rdata}, 10'h000);
    rst_n = 1;

    // R4 R2 R9 single written byte to slave 3
    access(1, 4'd3, 8'h9C);
    q = '{8'h9C}; check_pkt("R4 single", q);
    chk("R2 sa at first edge", sa_first, 3'd3);
    chk("R2 sa held after", spi_sa, 3'd3);
    chk("R9 first rise", (rise_t[0] - cs_fall_t) / TCK, HALF);
    for (int i = 1; i < rise_t.size(); i++)
      chk("R9 period", (rise_t[i] - rise_t[i-1]) / TCK, 2 * HALF);
    @(negedge clk);
    chk("R10 done one cycle", bus_done, 0);

    // R3 R4 three buffered bytes then write
    access(1, 4'd8, 8'h11); access(1, 4'd8, 8'h22); access(1, 4'd8, 8'h33);
    access(1, 4'd5, 8'h44);
    q = '{8'h11, 8'h22, 8'h33, 8'h44}; check_pkt("R4 order", q);

    // R3 full buffer plus two dropped loads
    for (int i = 0; i < 8; i++) access(1, 4'd8, 8'hB0 + 8'(i));
    access(1, 4'd2, 8'hEE);
    q = '{8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 8'hEE};
    check_pkt("R3 overflow", q);

    // R6 buffer emptied by previous access
    access(1, 4'd0, 8'h5A);
    q = '{8'h5A}; check_pkt("R6 empty", q);

    // R5 byte read with two buffered bytes
    access(1, 4'd8, 8'hC1); access(1, 4'd8, 8'hC2);
    access(0, 4'd6, 8'h00);
    q = '{8'hC1, 8'hC2, 8'h00}; check_pkt("R5 read", q);
    n = mosi_q.size();
    chk("R5 rdata", bus_rdata, rx_byte(n - 8));
    chk("R2 read sa", sa_first, 3'd6);

    // R7 R8 word read
    access(1, 4'd9, 8'h01);
    access(1, 4'd8, 8'h7E);
    access(0, 4'd7, 8'h00);
    q = '{8'h7E, 8'h00, 8'h00}; check_pkt("R7 word", q);
    n = mosi_q.size();
    chk("R7 low byte", bus_rdata, rx_byte(n - 8));
    access(0, 4'd8, 8'h00);
    chk("R8 high byte", bus_rdata, rx_byte(n - 16));

    // R7 word receive off again
    access(1, 4'd9, 8'h00);
    access(0, 4'd1, 8'h00);
    q = '{8'h00}; check_pkt("R7 byte again", q);
    chk("R7 byte rdata", bus_rdata, rx_byte(0));

    // R10 load attempted while busy is ignored
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 4'd4; bus_wdata = 8'h61;
    exp_sa = 3'd4; sa_known = 1;
    @(negedge clk);
    bus_req = 0;
    repeat (5) @(negedge clk);
    chk("R10 busy", bus_busy, 1);
    bus_req = 1; bus_addr = 4'd8; bus_wdata = 8'hEE;
    @(negedge clk);
    bus_req = 0;
    while (!bus_done) @(negedge clk);
    sa_known = 0;
    q = '{8'h61}; check_pkt("R10 first", q);
    @(negedge clk);
    chk("R10 idle after", bus_busy, 0);
    access(1, 4'd4, 8'h62);
    q = '{8'h62}; check_pkt("R10 dropped load", q);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule